// File: doc/BRIEF.md
# Delay-Line Phase Programming Sequencer

This block moves a clock-recovery delay line to a new sampling phase in the order the delay line needs. It owns a 32-bit configuration register and watches one feedback bit from the delay line, which reports whether the delayed clock output is currently enabled. A start pulse with a phase index from 0 to 15 sets off a fixed series of register updates. First the recovery loop and the clock output are switched off. Once the feedback shows the output has stopped, the phase is written as a reflected Gray code. The output is then switched back on, and once the feedback shows it running again, control passes back to the internal recovery loop.

Each wait on the feedback bit is a bounded poll: one sample per poll interval, at most a fixed number of samples. If the limit runs out, the sequence stops where it is and reports an error. A single-cycle done or error pulse ends every accepted request. The poll interval is counted from the system clock by a parameterized tick divider, so one interval equals 1 µs at the intended clock rate.

Top module: `dll_phase_seq`

## Requirements
- R1: After reset the configuration register holds CFG_RESET (default 0), and done, error and busy are low.
- R2: The first register update after an accepted start clears bit 17 (recovery enable) and bit 18 (output enable), sets bit 16 (line enable) and bit 19 (external select), and leaves every other bit unchanged.
- R3: The phase field is written only after the feedback has been sampled low. If the feedback stays high through every poll, the phase field keeps its old value.
- R4: The phase field is bits 23:20. Indices 0..15 are written as 0,1,3,2,6,7,5,4,12,13,15,14,10,11,9,8.
- R5: After the phase write, bit 18 is set. Bit 17 is set only after the feedback has been sampled high while bit 18 is set.
- R6: The last update sets bit 17 and clears bit 19, together with a one-cycle done pulse. When the feedback follows bit 18 with no delay, done is high in the 6th cycle after the start is accepted.
- R7: Each wait samples the feedback at most MAX_POLLS (50) times, TICKS_PER_POLL (200) cycles apart. The first sample falls in the cycle after the wait is entered. A timeout in the first wait raises error 2+49*200 = 9802 cycles after acceptance, and a timeout in the second wait raises it at 9805 cycles.
- R8: Error is a one-cycle pulse, done is not raised with it, and the register keeps the value the sequence had reached.
- R9: A start that arrives while busy is ignored: it changes neither the phase that is written nor whether another sequence runs.
- R10: Busy is high from the cycle after acceptance until the cycle in which done or error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to apply phase_i |
| phase_i | input | 4 | Phase index 0..15, sampled with start_i |
| ck_fb_i | input | 1 | Feedback: delay-line clock output currently enabled |
| cfg_o | output | 32 | Delay-line configuration register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: phase applied |
| err_o | output | 1 | One-cycle pulse: a poll wait timed out |

## Verification
The assertions assume the feedback input changes only in response to bit 18 of the register, or stays stuck at one level, and that the reset is applied before the first edge. They do not assume a start request is absent while busy. The bench drives the feedback from a model that echoes bit 18 after a chosen delay of 0 to 511 cycles, or holds it high or low. It changes inputs only at falling edges, and it pulses start once during a busy sequence to exercise the ignore path.

// File: rtl/dps_pkg.sv
// Package: shared constants, state and operation types for the phase sequencer.
// Assumes a 4-bit phase index and a 32-bit configuration register.
package dps_pkg;
    localparam int PH_W       = 4;
    localparam int CFG_W      = 32;
    localparam int B_LINE_EN  = 16;
    localparam int B_REC_EN   = 17;
    localparam int B_OUT_EN   = 18;
    localparam int B_EXT_SEL  = 19;
    localparam int SEL_LSB    = 20;

    typedef enum logic [2:0] {
        ST_IDLE, ST_QUIESCE, ST_WAIT_OFF, ST_LOAD, ST_ENABLE, ST_WAIT_ON, ST_HANDOVER
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_HOLD, OP_QUIESCE, OP_LOAD, OP_ENABLE, OP_HANDOVER
    } cfg_op_e;

    // Reflected binary code of a phase index.
    function automatic logic [PH_W-1:0] to_gray(input logic [PH_W-1:0] b);
        return b ^ (b >> 1);
    endfunction
endpackage

// File: rtl/dps_cfg_reg.sv
// Configuration register of the delay line. Applies one field update per cycle
// as selected by the controller. Assumes the controller issues at most one op per cycle.
module dps_cfg_reg
    import dps_pkg::*;
#(
    parameter logic [31:0] CFG_RESET = 32'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_op_e           op_i,
    input  logic [PH_W-1:0]   code_i,
    output logic [CFG_W-1:0]  cfg_o
);
    logic [CFG_W-1:0] cfg_q;

    // Register update: each op touches only its own bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else begin
            case (op_i)
                OP_QUIESCE: begin
                    cfg_q[B_REC_EN]  <= 1'b0;
                    cfg_q[B_OUT_EN]  <= 1'b0;
                    cfg_q[B_LINE_EN] <= 1'b1;
                    cfg_q[B_EXT_SEL] <= 1'b1;
                end
                OP_LOAD:     cfg_q[SEL_LSB +: PH_W] <= code_i;
                OP_ENABLE:   cfg_q[B_OUT_EN] <= 1'b1;
                OP_HANDOVER: begin
                    cfg_q[B_REC_EN]  <= 1'b1;
                    cfg_q[B_EXT_SEL] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign cfg_o = cfg_q;

    // R3
    sel_while_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[SEL_LSB +: PH_W] != $past(cfg_q[SEL_LSB +: PH_W])) |-> !$past(cfg_q[B_OUT_EN]));

    // R5
    rec_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_q[B_REC_EN]) |-> $past(cfg_q[B_OUT_EN]));
endmodule

// File: rtl/dps_poll_timer.sv
// Poll pacing: a tick divider marks poll instants, and a counter tracks how many
// polls the current wait has used. Assumes clr is pulsed before each wait starts.
module dps_poll_timer #(
    parameter int TICKS_PER_POLL = 200,
    parameter int MAX_POLLS      = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic poll_now_o,
    output logic last_poll_o
);
    localparam int TW = $clog2(TICKS_PER_POLL + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [TW-1:0] TICK_RELOAD = TW'(TICKS_PER_POLL - 1);
    localparam logic [PW-1:0] POLL_LAST   = PW'(MAX_POLLS - 1);

    logic [TW-1:0] tick_q;
    logic [PW-1:0] polls_q;

    assign poll_now_o  = (tick_q == '0);
    assign last_poll_o = (polls_q == POLL_LAST);

    // Tick and poll counters: restart on clr, advance while a wait runs.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            tick_q  <= '0;
            polls_q <= '0;
        end else if (run_i) begin
            if (poll_now_o) begin
                tick_q <= TICK_RELOAD;
                if (!last_poll_o) polls_q <= polls_q + 1'b1;
            end else begin
                tick_q <= tick_q - 1'b1;
            end
        end
    end

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        polls_q <= POLL_LAST);
endmodule

// File: rtl/dps_ctrl.sv
// Sequencer state machine: accepts a request, steps the register ops and evaluates
// the feedback at each poll instant. Assumes feedback reflects the output-enable bit.
module dps_ctrl
    import dps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PH_W-1:0]  phase_i,
    input  logic             fb_i,
    input  logic             poll_now_i,
    input  logic             last_poll_i,
    output cfg_op_e          op_o,
    output logic [PH_W-1:0]  code_o,
    output logic             clr_o,
    output logic             run_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);
    seq_state_e      state_q;
    logic [PH_W-1:0] phase_q;
    logic            done_q, err_q;

    // State, latched phase and result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    phase_q <= phase_i;
                    state_q <= ST_QUIESCE;
                end
                ST_QUIESCE:  state_q <= ST_WAIT_OFF;
                ST_WAIT_OFF: if (poll_now_i) begin
                    if (!fb_i) state_q <= ST_LOAD;
                    else if (last_poll_i) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_LOAD:     state_q <= ST_ENABLE;
                ST_ENABLE:   state_q <= ST_WAIT_ON;
                ST_WAIT_ON: if (poll_now_i) begin
                    if (fb_i) state_q <= ST_HANDOVER;
                    else if (last_poll_i) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_HANDOVER: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Register op and timer control decoded from the state.
    always_comb begin
        op_o  = OP_HOLD;
        clr_o = 1'b0;
        run_o = 1'b0;
        case (state_q)
            ST_QUIESCE:  begin op_o = OP_QUIESCE; clr_o = 1'b1; end
            ST_WAIT_OFF: run_o = 1'b1;
            ST_LOAD:     op_o = OP_LOAD;
            ST_ENABLE:   begin op_o = OP_ENABLE; clr_o = 1'b1; end
            ST_WAIT_ON:  run_o = 1'b1;
            ST_HANDOVER: op_o = OP_HANDOVER;
            default: ;
        endcase
    end

    assign code_o = to_gray(phase_q);
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign err_o  = err_q;

    // R8
    excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));
    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R7
    err_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(last_poll_i));
    // R10
    idle_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q || err_q) |-> !busy_o);
endmodule

// File: rtl/dll_phase_seq.sv
// Top: delay-line phase programming sequencer. Connects the controller, the poll
// timer and the configuration register. Assumes ck_fb_i is synchronous to clk.
module dll_phase_seq
    import dps_pkg::*;
#(
    parameter int          TICKS_PER_POLL = 200,
    parameter int          MAX_POLLS      = 50,
    parameter logic [31:0] CFG_RESET      = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [3:0]  phase_i,
    input  logic        ck_fb_i,
    output logic [31:0] cfg_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o
);
    cfg_op_e         op;
    logic [PH_W-1:0] code;
    logic            clr, run, poll_now, last_poll;

    dps_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_i(phase_i),
        .fb_i(ck_fb_i), .poll_now_i(poll_now), .last_poll_i(last_poll),
        .op_o(op), .code_o(code), .clr_o(clr), .run_o(run),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    dps_poll_timer #(.TICKS_PER_POLL(TICKS_PER_POLL), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .run_i(run),
        .poll_now_o(poll_now), .last_poll_o(last_poll)
    );

    dps_cfg_reg #(.CFG_RESET(CFG_RESET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .op_i(op), .code_i(code), .cfg_o(cfg_o)
    );

    // R2
    quiesce_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> (!cfg_o[B_REC_EN] && !cfg_o[B_OUT_EN] && cfg_o[B_LINE_EN] && cfg_o[B_EXT_SEL]));
endmodule

// File: tb/tb_dll_phase_seq.sv
module tb_dll_phase_seq;
    localparam int T = 200;
    localparam int N = 50;
    localparam logic [3:0] GRAY [16] = '{4'd0, 4'd1, 4'd3, 4'd2, 4'd6, 4'd7, 4'd5, 4'd4,
                                         4'd12, 4'd13, 4'd15, 4'd14, 4'd10, 4'd11, 4'd9, 4'd8};
    // vector: {phase[3:0], echo delay[8:0]}
    localparam logic [12:0] VEC [16] = '{
        {4'd0, 9'd1},   {4'd9, 9'd17},  {4'd3, 9'd200}, {4'd14, 9'd2},
        {4'd7, 9'd450}, {4'd12, 9'd0},  {4'd1, 9'd63},  {4'd15, 9'd511},
        {4'd4, 9'd5},   {4'd10, 9'd99}, {4'd2, 9'd201}, {4'd13, 9'd33},
        {4'd6, 9'd300}, {4'd8, 9'd7},   {4'd11, 9'd150},{4'd5, 9'd399}};

    logic clk = 0, rst_n = 0, start = 0, fb;
    logic [3:0] phase = 0;
    logic [31:0] cfg;
    logic busy, done, err;
    logic [511:0] hist = '0;
    int dly = 0, mode = 0, tests = 0, fails = 0;

    always #2.5 clk = ~clk;

    dll_phase_seq dut (.clk(clk), .rst_n(rst_n), .start_i(start), .phase_i(phase),
        .ck_fb_i(fb), .cfg_o(cfg), .busy_o(busy), .done_o(done), .err_o(err));

    always @(posedge clk) hist <= {hist[510:0], cfg[18]};
    always_comb begin
        if (mode == 1) fb = 1'b1;
        else if (mode == 2) fb = 1'b0;
        else if (dly == 0) fb = cfg[18];
        else fb = hist[dly-1];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_seq(input logic [3:0] ph, output int lat, output logic dn,
                           output logic er, output logic [31:0] c1);
        @(negedge clk); start = 1; phase = ph;
        @(posedge clk);
        @(negedge clk); start = 0;
        lat = 0; c1 = '0;
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (lat == 1) c1 = cfg;
            if (done || err) break;
        end
        dn = done; er = err;
    endtask

    initial begin
        for (int w = 0; w < 190000; w++) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lat;
        logic dn, er;
        logic [31:0] c1;
        logic [3:0] fld;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cfg", cfg, 32'h0);
        chk("R1 flags", {29'd0, busy, done, err}, 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R6 latency with immediate echo, R2 first update, R10 busy
        dly = 0;
        @(negedge clk); start = 1; phase = 4'd6;
        @(posedge clk); @(negedge clk); start = 0;
        chk("R10 busy after accept", {31'd0, busy}, 32'd1);
        lat = 0; c1 = '0;
        for (int k = 0; k < 100; k++) begin
            @(posedge clk); lat++; @(negedge clk);
            if (lat == 1) c1 = cfg;
            if (done || err) break;
        end
        chk("R2 quiesce value", c1, 32'h0009_0000);
        chk("R6 latency", lat, 6);
        chk("R6 done", {31'd0, done}, 32'd1);
        chk("R10 idle at done", {31'd0, busy}, 32'd0);
        chk("R6 final cfg", cfg, 32'h0007_0000 | (32'(GRAY[6]) << 20));
        @(negedge clk);
        chk("R6 done one cycle", {31'd0, done}, 32'd0);
        fld = GRAY[6];

        // R4 table of all phases with varied echo delays
        for (int i = 0; i < 16; i++) begin
            dly = int'(VEC[i][8:0]);
            run_seq(VEC[i][12:9], lat, dn, er, c1);
            chk("R2 quiesce keeps field", c1, 32'h0009_0000 | (32'(fld) << 20));
            chk("R4 done", {30'd0, dn, er}, 32'd2);
            chk("R4 gray field", cfg, 32'h0007_0000 | (32'(GRAY[VEC[i][12:9]]) << 20));
            fld = GRAY[VEC[i][12:9]];
        end

        // R3 R7 R8 feedback stuck high: timeout in first wait, field kept
        mode = 1;
        run_seq(4'd10, lat, dn, er, c1);
        chk("R7 off-wait timeout cycle", lat, 2 + (N - 1) * T);
        chk("R8 err without done", {30'd0, dn, er}, 32'd1);
        chk("R3 field kept on timeout", cfg, 32'h0009_0000 | (32'(fld) << 20));
        @(negedge clk);
        chk("R8 err one cycle", {31'd0, err}, 32'd0);

        // R5 R7 feedback stuck low: timeout in second wait
        mode = 2;
        run_seq(4'd13, lat, dn, er, c1);
        chk("R7 on-wait timeout cycle", lat, 5 + (N - 1) * T);
        chk("R5 err", {30'd0, dn, er}, 32'd1);
        chk("R5 output enabled, no handover", cfg, 32'h000D_0000 | (32'(GRAY[13]) << 20));
        fld = GRAY[13];

        // R9 start while busy ignored
        mode = 0; dly = 300;
        repeat (400) @(negedge clk);
        @(negedge clk); start = 1; phase = 4'd3;
        @(posedge clk); @(negedge clk); start = 0;
        repeat (10) @(negedge clk);
        start = 1; phase = 4'd12;
        @(negedge clk); start = 0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (done || err) break;
        end
        chk("R9 first phase applied", cfg, 32'h0007_0000 | (32'(GRAY[3]) << 20));
        repeat (30) @(negedge clk);
        chk("R9 no second run", {31'd0, busy}, 32'd0);
        chk("R9 cfg unchanged", cfg, 32'h0007_0000 | (32'(GRAY[3]) << 20));

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule